// File: doc/BRIEF.md
# Shutdown and Wake-Up Controller

This block sits in the always-on slow-clock domain (32768 Hz) of a chip and decides when the main supply may be switched off and when it must come back. Software shuts the system down by writing a command word that carries a fixed key. The block then drives its power-enable output low and watches a set of wake-up pins and an alarm line from the real-time clock.

Each wake-up pin has its own enable bit and its own active level. A pin that is enabled and sitting at its active level passes through a two-flop synchronizer and then a stability filter. The filter length is picked by a 3-bit index into a fixed, non-linear table of slow-clock counts. When a pin has stayed qualified for the selected number of cycles, or an enabled alarm arrives, power-enable is raised again. The cause is then latched in a status word that software reads, and clears by reading, once it is running again.

All registers are 32 bits wide and sit at byte offsets 0x0 (command), 0x4 (mode), 0x8 (status) and 0xC (pin configuration). Writes take effect at the clock edge that samples them. Read data is registered and is valid in the cycle after the read strobe.

Top module: `shdn_wake_ctrl`

## Requirements
- R1: After reset, pwr_en is 1 and the mode, status and pin configuration registers all read 0. A status of 0 means a plain power-on.
- R2: A write to offset 0x0 with bit 0 set and 0xA5 in bits 31:24 drives pwr_en low at that edge. A write with any other key, or with bit 0 clear, leaves pwr_en unchanged.
- R3: Offset 0xC bits 15:0 enable pins 0..15, and bits 31:16 give each pin's active level (1 = high, 0 = low). The register reads back as written. Offset 0x0 reads 0.
- R4: The mode register holds the filter index in bits 26:24. Indices 0..5 require N = 0, 3, 32, 512, 4096, 32768 cycles. If a qualifying level is present at the pin from edge E0 onward, pwr_en rises at edge E0+N+2 and not earlier. The two extra cycles are the synchronizer.
- R5: Filter indices 6 and 7 behave exactly as index 5 (N = 32768).
- R6: Mode bit 17 enables the alarm. While shut down, an alarm that is high at an edge with bit 17 set raises pwr_en at that edge. With bit 17 clear the alarm has no effect.
- R7: On a wake, status bit 16+i is set for every pin i whose filter completed in that cycle, so several pins can be recorded at once. Status bit 5 is set for an alarm wake. The mode register reads back only bits 26:24 and bit 17.
- R8: A read of offset 0x8 returns the status and clears it. A wake event recorded at the same edge as the read is kept and returned by the next read.
- R9: While pwr_en is 1, the pins and the alarm do not change pwr_en or status.
- R10: A pin that is disabled, or that sits at its inactive level, never wakes the system. With mode and pin configuration both 0, nothing wakes it.
- R11: A qualifying level that lasts fewer cycles than the filter length is discarded, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| wk_in | input | NUM_WK (16) | Asynchronous wake-up pins |
| rtc_alarm | input | 1 | Alarm from the real-time clock, synchronous to clk |
| pwr_en | output | 1 | System power enable, 1 = powered |

## Verification
A stuck or miscounted filter counter shows as pwr_en rising one or more cycles away from E0+N+2. The bench therefore checks pwr_en at exactly that edge and at the edge before it, for every index. A synchronizer stage too many or too few shifts every wake by a cycle and is caught in the first index-0 wake. A lost status bit, a wrong polarity sense or a clear-on-read that drops a same-edge event shows up at the very next status read. A wrong key compare or a wrong command-bit compare shows one edge after the command write, as pwr_en that fails to fall or that falls when it should not.

// File: rtl/shdn_pkg.sv
package shdn_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_MODE = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_PCFG = 4'hC;

  localparam logic [7:0] CMD_KEY  = 8'hA5;
  localparam int KEY_LSB      = 24;
  localparam int CMD_GO_BIT   = 0;
  localparam int FLT_LSB      = 24;
  localparam int FLT_IDX_W    = 3;
  localparam int ALARM_EN_BIT = 17;
  localparam int ALARM_ST_BIT = 5;
  localparam int PIN_ST_LSB   = 16;
  localparam int PIN_LVL_LSB  = 16;
  localparam int MAX_PINS     = 16;
  localparam int FLT_CNT_W    = 16;

  // Stable-cycle count for each filter index; the top indices saturate.
  function automatic logic [FLT_CNT_W-1:0] flt_len(input logic [FLT_IDX_W-1:0] idx);
    logic [FLT_CNT_W-1:0] n;
    case (idx)
      3'd0:    n = 16'd0;
      3'd1:    n = 16'd3;
      3'd2:    n = 16'd32;
      3'd3:    n = 16'd512;
      3'd4:    n = 16'd4096;
      default: n = 16'd32768;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/shdn_sync.sv
module shdn_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/shdn_filter.sv
module shdn_filter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qual,
  input  logic [CNT_W-1:0] len,
  output logic             hit
);
  logic [CNT_W-1:0] run_q;

  // Counts consecutive qualified cycles; any gap restarts from zero.
  always_ff @(posedge clk) begin
    if (rst || !qual) begin
      run_q <= '0;
    end else if (run_q != {CNT_W{1'b1}}) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign hit = qual && (run_q >= len);
endmodule

// File: rtl/shdn_regs.sv
module shdn_regs
  import shdn_pkg::*;
#(
  parameter int NUM_WK = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_WK-1:0]    pin_evt,
  input  logic                 alarm_evt,
  output logic                 off_cmd,
  output logic [FLT_IDX_W-1:0] flt_idx,
  output logic                 alarm_en,
  output logic [NUM_WK-1:0]    pin_en,
  output logic [NUM_WK-1:0]    pin_lvl,
  output logic [DATA_W-1:0]    status
);
  logic [NUM_WK-1:0] st_pin_q;
  logic              st_alarm_q;
  logic              wr_mode, wr_pcfg, rd_stat;
  logic [DATA_W-1:0] mode_word, pcfg_word, rd_mux;

  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign wr_pcfg = bus_wr && (bus_addr == OFS_PCFG);
  assign rd_stat = bus_rd && (bus_addr == OFS_STAT);
  assign off_cmd = bus_wr && (bus_addr == OFS_CMD) &&
                   (bus_wdata[KEY_LSB +: 8] == CMD_KEY) && bus_wdata[CMD_GO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_idx  <= '0;
      alarm_en <= 1'b0;
    end else if (wr_mode) begin
      flt_idx  <= bus_wdata[FLT_LSB +: FLT_IDX_W];
      alarm_en <= bus_wdata[ALARM_EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_en  <= '0;
      pin_lvl <= '0;
    end else if (wr_pcfg) begin
      pin_en  <= bus_wdata[NUM_WK-1:0];
      pin_lvl <= bus_wdata[PIN_LVL_LSB +: NUM_WK];
    end
  end

  // Clear on read, but keep whatever lands at the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_pin_q   <= '0;
      st_alarm_q <= 1'b0;
    end else if (rd_stat) begin
      st_pin_q   <= pin_evt;
      st_alarm_q <= alarm_evt;
    end else begin
      st_pin_q   <= st_pin_q | pin_evt;
      st_alarm_q <= st_alarm_q | alarm_evt;
    end
  end

  always_comb begin
    status = '0;
    status[PIN_ST_LSB +: NUM_WK] = st_pin_q;
    status[ALARM_ST_BIT]         = st_alarm_q;
    mode_word = '0;
    mode_word[FLT_LSB +: FLT_IDX_W] = flt_idx;
    mode_word[ALARM_EN_BIT]         = alarm_en;
    pcfg_word = '0;
    pcfg_word[NUM_WK-1:0]            = pin_en;
    pcfg_word[PIN_LVL_LSB +: NUM_WK] = pin_lvl;
    case (bus_addr)
      OFS_MODE: rd_mux = mode_word;
      OFS_STAT: rd_mux = status;
      OFS_PCFG: rd_mux = pcfg_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/shdn_wake_ctrl.sv
module shdn_wake_ctrl
  import shdn_pkg::*;
#(
  parameter int NUM_WK      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_WK-1:0] wk_in,
  input  logic              rtc_alarm,
  output logic              pwr_en
);
  logic [NUM_WK-1:0]    pin_s, pin_qual, pin_hit, pin_en, pin_lvl;
  logic [FLT_IDX_W-1:0] flt_idx;
  logic [FLT_CNT_W-1:0] flt_n;
  logic                 alarm_en, alarm_hit, off_cmd, asleep, wake;
  logic [DATA_W-1:0]    status;

  shdn_regs #(.NUM_WK(NUM_WK)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_evt   (pin_hit),
    .alarm_evt (alarm_hit),
    .off_cmd   (off_cmd),
    .flt_idx   (flt_idx),
    .alarm_en  (alarm_en),
    .pin_en    (pin_en),
    .pin_lvl   (pin_lvl),
    .status    (status)
  );

  shdn_sync #(.W(NUM_WK), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (wk_in),
    .q   (pin_s)
  );

  assign asleep   = !pwr_en;
  assign flt_n    = flt_len(flt_idx);
  assign pin_qual = asleep ? (pin_en & ~(pin_s ^ pin_lvl)) : '0;

  for (genvar g = 0; g < NUM_WK; g++) begin : g_flt
    shdn_filter #(.CNT_W(FLT_CNT_W)) u_flt (
      .clk  (clk),
      .rst  (rst),
      .qual (pin_qual[g]),
      .len  (flt_n),
      .hit  (pin_hit[g])
    );
  end

  assign alarm_hit = asleep && alarm_en && rtc_alarm;
  assign wake      = (|pin_hit) || alarm_hit;

  always_ff @(posedge clk) begin
    if (rst)                   pwr_en <= 1'b1;
    else if (asleep && wake)   pwr_en <= 1'b1;
    else if (!asleep && off_cmd) pwr_en <= 1'b0;
  end
endmodule

// File: rtl/shdn_wake_ctrl_chk.sv
module shdn_wake_ctrl_chk
  import shdn_pkg::*;
#(
  parameter int NUM_WK = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rtc_alarm,
  input logic              pwr_en,
  input logic              alarm_en,
  input logic [NUM_WK-1:0] pin_en,
  input logic [31:0]       status
);
  logic good_cmd;
  assign good_cmd = bus_wr && (bus_addr == 4'h0) &&
                    (bus_wdata[31:24] == 8'hA5) && bus_wdata[0];

  assert_shdn_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (good_cmd && pwr_en) |=> !pwr_en);

  assert_stay_on_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && !good_cmd) |=> pwr_en);

  assert_alarm_wake_R6: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && alarm_en && rtc_alarm) |=> pwr_en);

  assert_no_source_R10: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && (pin_en == '0) && !alarm_en) |=> !pwr_en);

  assert_cause_kept_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> (status != 32'h0));
endmodule

bind shdn_wake_ctrl shdn_wake_ctrl_chk #(.NUM_WK(NUM_WK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rtc_alarm (rtc_alarm),
  .pwr_en    (pwr_en),
  .alarm_en  (alarm_en),
  .pin_en    (pin_en),
  .status    (status)
);

// File: tb/shdn_wake_ctrl_tb.sv
module shdn_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NW-1:0] wk_in = '0;
  logic          rtc_alarm = 1'b0;
  logic          pwr_en;
  int            n_chk = 0, n_bad = 0;
  logic [31:0]   d;

  always #(CLK_PERIOD/2) clk = ~clk;

  shdn_wake_ctrl #(.NUM_WK(NW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wk_in(wk_in),
    .rtc_alarm(rtc_alarm), .pwr_en(pwr_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  function automatic int exp_len(input int idx);
    case (idx)
      0: return 0;
      1: return 3;
      2: return 32;
      3: return 512;
      4: return 4096;
      default: return 32768;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4 run did not finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pwr_en == 1'b1, "R1 pwr_en", {31'b0, pwr_en}, 32'h1);
    rd(4'h4, d); chk(d == 0, "R1 mode", d, 0);
    rd(4'h8, d); chk(d == 0, "R1 status", d, 0);
    rd(4'hC, d); chk(d == 0, "R1 pcfg", d, 0);

    // R3 / R7 readback
    wr(4'hC, 32'h1234_ABCD); rd(4'hC, d); chk(d == 32'h1234_ABCD, "R3 pcfg readback", d, 32'h1234_ABCD);
    rd(4'h0, d); chk(d == 0, "R3 cmd reads zero", d, 0);
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d); chk(d == 32'h0702_0000, "R7 mode readback", d, 32'h0702_0000);
    wr(4'h4, 0); wr(4'hC, 0);

    // R2 key check
    wr(4'h0, 32'h5A00_0001); chk(pwr_en == 1'b1, "R2 bad key", {31'b0, pwr_en}, 1);
    wr(4'h0, 32'hA500_0000); chk(pwr_en == 1'b1, "R2 go bit clear", {31'b0, pwr_en}, 1);

    // R10 no sources configured
    wr(4'h0, 32'hA500_0001); chk(pwr_en == 1'b0, "R2 good key", {31'b0, pwr_en}, 0);
    wk_in = '1; rtc_alarm = 1'b1; repeat (6) @(negedge clk);
    wk_in = '0; repeat (6) @(negedge clk);
    chk(pwr_en == 1'b0, "R10 all cleared", {31'b0, pwr_en}, 0);
    // R6 alarm ignored while disabled, then enabling it wakes next edge
    wr(4'h4, 32'h0002_0000);
    @(negedge clk);
    chk(pwr_en == 1'b1, "R6 alarm wake", {31'b0, pwr_en}, 1);
    rtc_alarm = 1'b0;
    rd(4'h8, d); chk(d == 32'h20, "R7 alarm status", d, 32'h20);

    // R4 / R5 filter sweep over all indices on pin 3, active high
    for (int idx = 0; idx < 8; idx++) begin
      int n;
      n = exp_len(idx);
      wk_in = '0;
      wr(4'hC, 32'h0008_0008);
      wr(4'h4, idx << 24);
      wr(4'h0, 32'hA500_0001);
      wk_in[3] = 1'b1;
      repeat (n + 2) @(negedge clk);
      chk(pwr_en == 1'b0, $sformatf("R4 R5 early idx%0d", idx), {31'b0, pwr_en}, 0);
      @(negedge clk);
      chk(pwr_en == 1'b1, $sformatf("R4 R5 on time idx%0d", idx), {31'b0, pwr_en}, 1);
      rd(4'h8, d); chk(d == 32'h0008_0000, "R7 pin3 status", d, 32'h0008_0000);
      if (idx == 0) begin
        repeat (10) @(negedge clk);
        rd(4'h8, d); chk(d == 0, "R8 R9 cleared and no awake capture", d, 0);
        chk(pwr_en == 1'b1, "R9 stays on", {31'b0, pwr_en}, 1);
      end
    end

    // R3 / R10 every pin, both levels, index 0
    for (int i = 0; i < NW; i++) begin
      for (int p = 0; p < 2; p++) begin
        wk_in = (p == 1) ? '0 : '1;
        wr(4'hC, (32'h1 << i) | ((p == 1) ? (32'h1 << (16 + i)) : 32'h0));
        wr(4'h4, 0);
        wr(4'h0, 32'hA500_0001);
        repeat (4) @(negedge clk);
        chk(pwr_en == 1'b0, $sformatf("R10 inactive level pin%0d lvl%0d", i, p), {31'b0, pwr_en}, 0);
        wk_in[i] = ~wk_in[i];
        repeat (2) @(negedge clk);
        chk(pwr_en == 1'b0, "R4 idx0 early", {31'b0, pwr_en}, 0);
        @(negedge clk);
        chk(pwr_en == 1'b1, $sformatf("R3 pin%0d lvl%0d wake", i, p), {31'b0, pwr_en}, 1);
        rd(4'h8, d); chk(d == (32'h1 << (16 + i)), "R7 single pin status", d, 32'h1 << (16 + i));
      end
    end

    // R10 disabled pin, R7 simultaneous pins
    wk_in = '0;
    wr(4'hC, 32'h0224_0224); wr(4'h4, 0);
    wr(4'h0, 32'hA500_0001);
    wk_in[1] = 1'b1; wk_in[0] = 1'b1; repeat (6) @(negedge clk);
    chk(pwr_en == 1'b0, "R10 disabled pins", {31'b0, pwr_en}, 0);
    wk_in[2] = 1'b1; wk_in[5] = 1'b1; wk_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwr_en == 1'b1, "R7 multi wake", {31'b0, pwr_en}, 1);
    rd(4'h8, d); chk(d == 32'h0224_0000, "R7 multi status", d, 32'h0224_0000);

    // R11 short pulse discarded
    wk_in = '0;
    wr(4'hC, 32'h0001_0001); wr(4'h4, 2 << 24);
    wr(4'h0, 32'hA500_0001);
    wk_in[0] = 1'b1; repeat (20) @(negedge clk);
    wk_in[0] = 1'b0; repeat (20) @(negedge clk);
    wk_in[0] = 1'b1; repeat (20) @(negedge clk);
    wk_in[0] = 1'b0; repeat (40) @(negedge clk);
    chk(pwr_en == 1'b0, "R11 short pulses", {31'b0, pwr_en}, 0);
    rtc_alarm = 1'b1;
    wr(4'h4, 32'h0202_0000);
    @(negedge clk); rtc_alarm = 1'b0;
    chk(pwr_en == 1'b1, "R6 alarm exit", {31'b0, pwr_en}, 1);
    rd(4'h8, d); chk(d == 32'h20, "R11 only alarm recorded", d, 32'h20);

    // R8 event at same edge as status read
    wr(4'hC, 0); wr(4'h4, 32'h0002_0000);
    wr(4'h0, 32'hA500_0001);
    rtc_alarm = 1'b1; bus_rd = 1'b1; bus_addr = 4'h8;
    @(negedge clk); bus_rd = 1'b0; rtc_alarm = 1'b0; d = bus_rdata;
    chk(d == 0, "R8 read sees old value", d, 0);
    chk(pwr_en == 1'b1, "R6 wake with read", {31'b0, pwr_en}, 1);
    rd(4'h8, d); chk(d == 32'h20, "R8 same-edge event kept", d, 32'h20);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule